// File: doc/BRIEF.md
# Serial Converter Output Port with Power-State Tracking

This block is the digital half of a 12-bit sampling converter that talks over a three-wire serial port. A host raises a start strobe to begin a conversion. It then toggles a serial clock. On each rising clock edge the block advances one frame position. The frame has one reference-ready status bit followed by the sample word, most significant bit first. The serial data line is driven only during the frame. Outside the frame it is released to high impedance. An enable output steers the pad driver.

The same two host inputs also choose a power state. Start-strobe edges that arrive with no serial clock edge between them are counted: two of them put the block in a nap state and four put it in a sleep state. Any serial clock edge brings it back to active. Nap keeps the reference-ready flag. Sleep clears it, and after waking the flag comes back only when two periods have passed in turn. The first is a slew period that also needs the external reference-settled input to be high. The second is a settling period. Both are cycle counts given as parameters.

Both host inputs and the settled input are resynchronised into the fast system clock through two-flop synchronizers, and edges are taken from the synchronised levels. Every port reaction therefore lands on the third system clock edge after the input changes.

Top module: `sadc_port`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted start, `dout_oe_o` is 0, `dout_o` is 0 and `pwr_o` is 0 (active).
- R2: A start-strobe rising edge in the active state, outside the ignore window, starts a conversion and captures `sample_i` at that moment; later changes to `sample_i` do not alter the frame.
- R3: Start-strobe rising edges during the ignore window (until the 14th serial clock rising edge of the frame, with DATA_W=12) neither restart nor disturb the frame.
- R4: On the 2nd serial clock rising edge after a start, `dout_oe_o` goes to 1 and `dout_o` carries the reference-ready flag (1 = ready).
- R5: On rising edges 3 to 14 the sample bits leave MSB first, one per edge; `dout_o` changes only on a serial clock or start-strobe rising edge.
- R6: The 15th rising edge releases the line (`dout_oe_o` = 0), and it stays released until a new conversion starts.
- R7: `pwr_o` encodes 0 = active, 1 = nap, 2 = sleep. Two start-strobe rising edges with no serial clock rising edge between them give nap, a third keeps nap, and a fourth gives sleep. Every serial clock rising edge restarts this count.
- R8: A serial clock rising edge returns the block to active. Start edges in nap or sleep start no conversion, and entering nap or sleep releases the line at once.
- R9: Nap preserves the reference-ready flag: a frame started right after waking from nap reports 1 if the flag was 1 before.
- R10: Sleep clears the flag. After waking, it reads 0 until SLEW_CYC cycles have passed with `ref_ok_i` high and then SETTLE_CYC further cycles; the slew period does not end while `ref_ok_i` is low. Reset starts the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast relative to the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Conversion start strobe, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sample_i | input | DATA_W | Parallel sample word from the converter core |
| ref_ok_i | input | 1 | Reference output has finished slewing |
| dout_o | output | 1 | Serial data value |
| dout_oe_o | output | 1 | Drive enable for the data pad; 0 = high impedance |
| pwr_o | output | 2 | Power state: 0 active, 1 nap, 2 sleep |

## Verification
A wrong frame position counter shows on the first frame. The status bit or a sample bit appears one serial clock edge early or late, or the line is still driven on the release edge, and each of these is visible three system clocks after the offending edge. A wrong strobe-edge count shows as `pwr_o` taking nap or sleep on the wrong edge, or as an injected mid-frame strobe corrupting the remaining bits. A wrong reference state machine shows only in the status bit of the next frame, so the bench places frames just after wake and again well after the settling time, with the settled input both low and high.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    REF_SLEW   = 2'd0,
    REF_SETTLE = 2'd1,
    REF_READY  = 2'd2
  } ref_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sadc_power.sv
module sadc_power
  import sadc_pkg::*;
#(
  parameter int NAP_EDGES   = 2,
  parameter int SLEEP_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise_i,
  input  logic strobe_rise_i,
  output pwr_e pwr_o,
  output logic low_o
);
  localparam int EW = $clog2(SLEEP_EDGES + 1);

  pwr_e          pwr_q, pwr_n;
  logic [EW-1:0] ecnt_q, ecnt_n;

  always_comb begin
    pwr_n  = pwr_q;
    ecnt_n = ecnt_q;
    if (sclk_rise_i) begin
      pwr_n  = PWR_ACTIVE;
      ecnt_n = strobe_rise_i ? EW'(1) : '0;
    end else if (strobe_rise_i) begin
      if (ecnt_q != EW'(SLEEP_EDGES)) ecnt_n = ecnt_q + EW'(1);
      if (ecnt_n >= EW'(SLEEP_EDGES))    pwr_n = PWR_SLEEP;
      else if (ecnt_n >= EW'(NAP_EDGES)) pwr_n = PWR_NAP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= PWR_ACTIVE;
      ecnt_q <= '0;
    end else begin
      pwr_q  <= pwr_n;
      ecnt_q <= ecnt_n;
    end
  end

  assign pwr_o = pwr_q;
  assign low_o = (pwr_n != PWR_ACTIVE);
endmodule

// File: rtl/sadc_refmon.sv
module sadc_refmon
  import sadc_pkg::*;
#(
  parameter int SLEW_CYC   = 200,
  parameter int SETTLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic ok_i,
  output logic rdy_o
);
  localparam int MAXC = (SLEW_CYC > SETTLE_CYC) ? SLEW_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  ref_e          ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (sleep_i) begin
      ph_n  = REF_SLEW;
      cnt_n = '0;
    end else begin
      case (ph_q)
        REF_SLEW: begin
          if (cnt_q != CW'(SLEW_CYC - 1)) cnt_n = cnt_q + CW'(1);
          else if (ok_i) begin
            ph_n  = REF_SETTLE;
            cnt_n = '0;
          end
        end
        REF_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            ph_n  = REF_READY;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        default: ph_n = REF_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= REF_SLEW;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  assign rdy_o = (ph_q == REF_READY);
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              sclk_rise_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ref_rdy_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              busy_o
);
  localparam int STAT_POS = 2;
  localparam int IGN      = DATA_W + 2;
  localparam int LAST     = DATA_W + 3;
  localparam int CW       = $clog2(LAST + 1);

  logic              act_q, act_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [DATA_W-1:0] shr_q, shr_n;
  logic              dout_q, dout_n;
  logic              oe_q, oe_n;

  always_comb begin
    act_n  = act_q;
    cnt_n  = cnt_q;
    shr_n  = shr_q;
    dout_n = dout_q;
    oe_n   = oe_q;
    if (abort_i) begin
      act_n  = 1'b0;
      oe_n   = 1'b0;
      dout_n = 1'b0;
    end else if (start_i) begin
      act_n  = 1'b1;
      cnt_n  = '0;
      shr_n  = sample_i;
      oe_n   = 1'b0;
      dout_n = 1'b0;
    end else if (act_q && sclk_rise_i) begin
      cnt_n = cnt_q + CW'(1);
      if (cnt_n == CW'(STAT_POS)) begin
        oe_n   = 1'b1;
        dout_n = ref_rdy_i;
      end else if (cnt_n > CW'(STAT_POS) && cnt_n < CW'(LAST)) begin
        dout_n = shr_q[DATA_W-1];
        shr_n  = {shr_q[DATA_W-2:0], 1'b0};
      end else if (cnt_n == CW'(LAST)) begin
        act_n  = 1'b0;
        oe_n   = 1'b0;
        dout_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      shr_q  <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      shr_q  <= shr_n;
      dout_q <= dout_n;
      oe_q   <= oe_n;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = oe_q;
  assign busy_o    = act_q && (cnt_q < CW'(IGN));
endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int NAP_EDGES   = 2,
  parameter int SLEEP_EDGES = 4,
  parameter int SLEW_CYC    = 200,
  parameter int SETTLE_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ref_ok_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [1:0]        pwr_o
);
  logic [1:0] rst_ff_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= 2'b00;
    else        rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_sn = rst_ff_q[1];

  logic [2:0] sync_q;
  sadc_sync #(.W(3), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d_i  ({ref_ok_i, sclk_i, strobe_i}),
    .q_o  (sync_q)
  );

  logic strobe_d_q, sclk_d_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      strobe_d_q <= 1'b0;
      sclk_d_q   <= 1'b0;
    end else begin
      strobe_d_q <= sync_q[0];
      sclk_d_q   <= sync_q[1];
    end
  end

  logic strobe_rise, sclk_rise;
  assign strobe_rise = sync_q[0] & ~strobe_d_q;
  assign sclk_rise   = sync_q[1] & ~sclk_d_q;

  pwr_e pwr;
  logic go_low;
  sadc_power #(.NAP_EDGES(NAP_EDGES), .SLEEP_EDGES(SLEEP_EDGES)) u_power (
    .clk          (clk),
    .rst_n        (rst_sn),
    .sclk_rise_i  (sclk_rise),
    .strobe_rise_i(strobe_rise),
    .pwr_o        (pwr),
    .low_o        (go_low)
  );

  logic ref_rdy;
  sadc_refmon #(.SLEW_CYC(SLEW_CYC), .SETTLE_CYC(SETTLE_CYC)) u_ref (
    .clk    (clk),
    .rst_n  (rst_sn),
    .sleep_i(pwr == PWR_SLEEP),
    .ok_i   (sync_q[2]),
    .rdy_o  (ref_rdy)
  );

  logic busy, start;
  assign start = strobe_rise && (pwr == PWR_ACTIVE) && !busy;

  sadc_frame #(.DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start_i    (start),
    .abort_i    (go_low),
    .sclk_rise_i(sclk_rise),
    .sample_i   (sample_i),
    .ref_rdy_i  (ref_rdy),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o),
    .busy_o     (busy)
  );

  assign pwr_o = pwr;
endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_rise,
  input logic       strobe_rise,
  input logic [1:0] pwr,
  input logic       ref_rdy,
  input logic       dout,
  input logic       dout_oe
);
  // R4
  oe_rise_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(sclk_rise));

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sclk_rise && !strobe_rise) |-> ($stable(dout) && $stable(dout_oe)));

  // R7
  sleep_via_nap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr == 2'd2 && $past(pwr) != 2'd2) |-> ($past(pwr) == 2'd1 && $past(strobe_rise)));

  // R8
  wake_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sclk_rise) |-> (pwr == 2'd0));

  // R8
  quiet_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr != 2'd0) |-> !dout_oe);

  // R10
  sleep_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr == 2'd2) |-> !ref_rdy);
endmodule

bind sadc_port sadc_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .sclk_rise  (sclk_rise),
  .strobe_rise(strobe_rise),
  .pwr        (pwr_o),
  .ref_rdy    (ref_rdy),
  .dout       (dout_o),
  .dout_oe    (dout_oe_o)
);

// File: tb/sadc_port_tb.sv
module sadc_port_tb;
  localparam int DW     = 12;
  localparam int SLEW   = 200;
  localparam int SETTLE = 300;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe, sclk, ref_ok;
  logic [DW-1:0] sample;
  logic          dout, dout_oe;
  logic [1:0]    pwr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sadc_port #(.DATA_W(DW), .SLEW_CYC(SLEW), .SETTLE_CYC(SETTLE)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe),
    .sclk_i   (sclk),
    .sample_i (sample),
    .ref_ok_i (ref_ok),
    .dout_o   (dout),
    .dout_oe_o(dout_oe),
    .pwr_o    (pwr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sclk_hi();
    @(negedge clk) sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sclk_lo();
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe_pulse();
    @(negedge clk) strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // One frame: start, 15 serial edges, two extra edges; inj = edge after which a stray strobe is fired
  task automatic run_frame(input logic [DW-1:0] smp, input int status, input int inj);
    int prev;
    sample = smp;
    strobe_pulse();
    sample = ~smp;
    chk("R2 line released after start", dout_oe, 0);
    prev = dout;
    for (int k = 1; k <= DW + 3; k++) begin
      sclk_hi();
      if (k == 1) chk("R4 no drive on first edge", dout_oe, 0);
      else if (k == 2) begin
        chk("R4 enable on second edge", dout_oe, 1);
        chk("R4 status bit", dout, status);
      end else if (k <= DW + 2) begin
        chk("R5 enable during data", dout_oe, 1);
        chk("R5 data bit MSB first", dout, int'(smp[DW - 1 - (k - 3)]));
      end else begin
        chk("R6 release on 15th edge", dout_oe, 0);
      end
      prev = dout;
      sclk_lo();
      chk("R5 hold between edges", dout, prev);
      if (k == inj) begin
        strobe_pulse();
        chk("R3 stray strobe keeps pwr", pwr, 0);
        chk("R3 stray strobe keeps line", dout, prev);
      end
    end
    for (int j = 0; j < 2; j++) begin
      sclk_hi();
      chk("R6 stays released", dout_oe, 0);
      sclk_lo();
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    strobe = 1'b0;
    sclk   = 1'b0;
    ref_ok = 1'b1;
    sample = '0;
    repeat (5) @(negedge clk);
    chk("R1 reset oe", dout_oe, 0);
    chk("R1 reset dout", dout, 0);
    chk("R1 reset pwr", pwr, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle oe", dout_oe, 0);

    // R10: reference still cold right after reset
    run_frame(12'hA5A, 0, 0);
    repeat (SLEW + SETTLE + 20) @(negedge clk);

    // R2 R5: sweep of sample words, flag ready
    run_frame(12'h000, 1, 0);
    run_frame(12'hFFF, 1, 0);
    run_frame(12'h800, 1, 1);
    run_frame(12'h001, 1, 13);
    run_frame(12'h5A5, 1, 5);
    for (int i = 0; i < 32; i++)
      run_frame(DW'((i * 1237 + 77) & 12'hFFF), 1, 0);

    // R7 R8 R9: nap, strobe in nap, wake
    strobe_pulse();
    chk("R7 one strobe stays active", pwr, 0);
    strobe_pulse();
    chk("R7 two strobes give nap", pwr, 1);
    chk("R8 nap releases line", dout_oe, 0);
    strobe_pulse();
    chk("R7 three strobes keep nap", pwr, 1);
    sclk_hi();
    chk("R8 wake from nap", pwr, 0);
    chk("R8 no frame from nap strobes", dout_oe, 0);
    sclk_lo();
    sclk_hi();
    chk("R8 still no frame", dout_oe, 0);
    sclk_lo();
    run_frame(12'h3C7, 1, 0);  // R9 flag kept

    // R7 R10: sleep and re-settle
    for (int i = 0; i < 4; i++) strobe_pulse();
    chk("R7 four strobes give sleep", pwr, 2);
    sclk_hi();
    chk("R8 wake from sleep", pwr, 0);
    sclk_lo();
    run_frame(12'h1E1, 0, 0);
    repeat (SLEW + SETTLE + 20) @(negedge clk);
    run_frame(12'h1E1, 1, 0);

    // R10: slew cannot end with the settled input low
    ref_ok = 1'b0;
    for (int i = 0; i < 4; i++) strobe_pulse();
    chk("R7 sleep again", pwr, 2);
    sclk_hi();
    sclk_lo();
    repeat (SLEW + SETTLE + 200) @(negedge clk);
    run_frame(12'h6B2, 0, 0);
    ref_ok = 1'b1;
    repeat (SLEW + SETTLE + 20) @(negedge clk);
    run_frame(12'h6B2, 1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0 (run hung)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule